// File: doc/BRIEF.md
# Instruction Dispatch Gate

This block sits between instruction decode and the scheduler. Each cycle it looks at one decoded instruction descriptor, offered on a valid/ready handshake. It decides whether that instruction may leave for the scheduler. The descriptor carries three numbers: a micro-op count, a count of destination registers to rename, and a count of scheduler-buffer entries the instruction needs. Three free-count inputs report the free space in the reorder buffer, the physical register pool and the scheduler buffer. The instruction is accepted only when all three resources can hold it and a dispatch slot is free.

At most `DISP_W` micro-ops leave per cycle. An instruction with more micro-ops than that is accepted once and then drained over later cycles through a carry-over count. That remainder takes slots ahead of any new instruction. Any slots left over in the cycle where the remainder finishes may go to the next instruction. The block keeps no instruction storage: a refused instruction stays upstream because ready is low. Every refused cycle is charged to one cause and counted in a saturating counter for that cause.

Top module: `dispatch_gate`

## Requirements
- R1: `in_ready` is low whenever `rob_free` is smaller than `in_uops`.
- R2: `in_ready` is low whenever `preg_free` is smaller than `in_dsts`.
- R3: `in_ready` is low whenever `sbuf_free` is smaller than `in_bufs`.
- R4: `disp_uops` never exceeds `DISP_W`. It equals the carried-over micro-ops served this cycle plus the micro-ops of a newly accepted instruction placed in the slots left over.
- R5: An accepted instruction whose micro-ops do not fit in the free slots leaves the rest in a carry-over count. That count is served first on following cycles, up to `DISP_W` per cycle. While the carry-over count is at least `DISP_W`, `in_ready` is low.
- R6: In a cycle where the carry-over needs fewer than `DISP_W` slots, the remaining slots (`DISP_W` minus the carry served) are free. If all three resource checks pass, a new instruction is accepted in that same cycle.
- R7: `alloc` pulses only in a cycle where `in_valid` and `in_ready` are both high. In that cycle `rob_alloc_n`, `preg_alloc_n` and `sbuf_alloc_n` equal the full `in_uops`, `in_dsts` and `in_bufs`. In every other cycle all three are zero, including the cycles that drain a carried-over instruction.
- R8: Each cycle with `in_valid` high and `in_ready` low increments exactly one stall counter. The cause is the first failing check in this order: reorder buffer (`stall_rob`), register pool (`stall_preg`), scheduler buffer (`stall_sbuf`), dispatch width (`stall_width`).
- R9: A stall counter that holds all ones stays at all ones.
- R10: `done_new` pulses when a newly accepted instruction sends all of its micro-ops in its acceptance cycle, including an instruction with zero micro-ops. `done_carry` pulses when the last carried-over micro-op is sent.
- R11: A synchronous active-high `rst` clears the carry-over count and all four stall counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_uops | input | UOP_W | Micro-op count of the instruction |
| in_dsts | input | DST_W | Destination registers to rename |
| in_bufs | input | BUF_W | Scheduler-buffer entries needed |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| rob_free | input | FREE_W | Free reorder-buffer entries |
| preg_free | input | FREE_W | Free physical registers |
| sbuf_free | input | FREE_W | Free scheduler-buffer entries |
| alloc | output | 1 | Allocation pulse on acceptance |
| rob_alloc_n | output | UOP_W | Reorder-buffer entries to allocate |
| preg_alloc_n | output | DST_W | Physical registers to allocate |
| sbuf_alloc_n | output | BUF_W | Scheduler-buffer entries to allocate |
| disp_uops | output | clog2(DISP_W+1) | Micro-ops dispatched this cycle |
| done_carry | output | 1 | Last micro-op of a carried-over instruction sent |
| done_new | output | 1 | Newly accepted instruction fully sent |
| stall_rob | output | CNT_W | Stall cycles charged to the reorder buffer |
| stall_preg | output | CNT_W | Stall cycles charged to the register pool |
| stall_sbuf | output | CNT_W | Stall cycles charged to the scheduler buffer |
| stall_width | output | CNT_W | Stall cycles charged to dispatch width |

## Verification
The properties assume that the three free counts are settled values from the owning units before the clock edge. They also assume that the descriptor fields are meaningful whenever `in_valid` is high. The carry-drain property also assumes that reset does not strike in the middle of a drain. The stimulus drives descriptors and free counts only on the falling edge, so every value is stable across the rising edge. It limits micro-op counts to the range of `UOP_W`. It applies reset during a pending carry-over only through the reset task, which holds reset for two full cycles. Free counts are swept through values that are short, exactly sufficient and plentiful for each resource, both alone and together with a pending carry-over.

// File: rtl/dg_pkg.sv
package dg_pkg;

    localparam int unsigned DG_DISP_W = 4;
    localparam int unsigned DG_UOP_W  = 4;
    localparam int unsigned DG_DST_W  = 3;
    localparam int unsigned DG_BUF_W  = 3;
    localparam int unsigned DG_FREE_W = 7;
    localparam int unsigned DG_CNT_W  = 32;
    localparam int unsigned DG_NCAUSE = 4;

    // Order of the enum values is the charging priority of a stall.
    typedef enum logic [1:0] {
        SC_ROB   = 2'd0,
        SC_PREG  = 2'd1,
        SC_SBUF  = 2'd2,
        SC_WIDTH = 2'd3
    } stall_cause_e;

    typedef struct packed {
        logic         ok;
        stall_cause_e cause;
    } gate_verdict_t;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dg_resource_check.sv
module dg_resource_check
    import dg_pkg::*;
#(
    parameter int unsigned UOP_W  = DG_UOP_W,
    parameter int unsigned DST_W  = DG_DST_W,
    parameter int unsigned BUF_W  = DG_BUF_W,
    parameter int unsigned FREE_W = DG_FREE_W
) (
    input  logic [UOP_W-1:0]  need_uops,
    input  logic [DST_W-1:0]  need_dsts,
    input  logic [BUF_W-1:0]  need_bufs,
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] preg_free,
    input  logic [FREE_W-1:0] sbuf_free,
    input  logic              width_block,
    output gate_verdict_t     verdict
);

    logic rob_short;
    logic preg_short;
    logic sbuf_short;

    always_comb begin
        rob_short  = 32'(need_uops) > 32'(rob_free);
        preg_short = 32'(need_dsts) > 32'(preg_free);
        sbuf_short = 32'(need_bufs) > 32'(sbuf_free);

        verdict.ok = !(rob_short || preg_short || sbuf_short || width_block);

        if (rob_short)       verdict.cause = SC_ROB;
        else if (preg_short) verdict.cause = SC_PREG;
        else if (sbuf_short) verdict.cause = SC_SBUF;
        else                 verdict.cause = SC_WIDTH;
    end

endmodule

// File: rtl/dg_slots.sv
module dg_slots
    import dg_pkg::*;
#(
    parameter int unsigned DISP_W = DG_DISP_W,
    parameter int unsigned UOP_W  = DG_UOP_W,
    parameter int unsigned SLOT_W = $clog2(DISP_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [UOP_W-1:0]  new_uops,
    output logic [UOP_W-1:0]  carry_q,
    output logic              width_block,
    output logic [SLOT_W-1:0] disp_uops,
    output logic              done_carry,
    output logic              done_new
);

    int unsigned served;
    int unsigned rest;
    int unsigned avail;
    int unsigned new_now;
    int unsigned carry_next;

    always_comb begin
        // The pending remainder takes slots first.
        served      = umin(32'(carry_q), DISP_W);
        rest        = 32'(carry_q) - served;
        avail       = DISP_W - served;
        width_block = (avail == 0);

        // The new instruction takes the slots that are left over.
        new_now     = accept ? umin(32'(new_uops), avail) : 0;
        carry_next  = rest + (accept ? (32'(new_uops) - new_now) : 0);

        disp_uops   = SLOT_W'(served + new_now);
        done_carry  = (carry_q != '0) && (rest == 0);
        done_new    = accept && (32'(new_uops) <= avail);
    end

    always_ff @(posedge clk) begin
        if (rst) carry_q <= '0;
        else     carry_q <= UOP_W'(carry_next);
    end

endmodule

// File: rtl/dg_stall_bank.sv
module dg_stall_bank
    import dg_pkg::*;
#(
    parameter int unsigned NCAUSE = DG_NCAUSE,
    parameter int unsigned CNT_W  = DG_CNT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          stall_evt,
    input  stall_cause_e                  cause,
    output logic [NCAUSE-1:0][CNT_W-1:0]  counts
);

    for (genvar i = 0; i < NCAUSE; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        assign hit = stall_evt && (32'(cause) == i);

        always_ff @(posedge clk) begin
            if (rst)                       cnt_q <= '0;
            else if (hit && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
        end

        assign counts[i] = cnt_q;
    end

endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate
    import dg_pkg::*;
#(
    parameter int unsigned DISP_W = DG_DISP_W,
    parameter int unsigned UOP_W  = DG_UOP_W,
    parameter int unsigned DST_W  = DG_DST_W,
    parameter int unsigned BUF_W  = DG_BUF_W,
    parameter int unsigned FREE_W = DG_FREE_W,
    parameter int unsigned CNT_W  = DG_CNT_W,
    localparam int unsigned SLOT_W = $clog2(DISP_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [UOP_W-1:0]  in_uops,
    input  logic [DST_W-1:0]  in_dsts,
    input  logic [BUF_W-1:0]  in_bufs,
    output logic              in_ready,
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] preg_free,
    input  logic [FREE_W-1:0] sbuf_free,
    output logic              alloc,
    output logic [UOP_W-1:0]  rob_alloc_n,
    output logic [DST_W-1:0]  preg_alloc_n,
    output logic [BUF_W-1:0]  sbuf_alloc_n,
    output logic [SLOT_W-1:0] disp_uops,
    output logic              done_carry,
    output logic              done_new,
    output logic [CNT_W-1:0]  stall_rob,
    output logic [CNT_W-1:0]  stall_preg,
    output logic [CNT_W-1:0]  stall_sbuf,
    output logic [CNT_W-1:0]  stall_width
);

    gate_verdict_t                   verdict;
    logic                            width_block;
    logic                            accept;
    logic                            stall_evt;
    logic [UOP_W-1:0]                carry_q;
    logic [DG_NCAUSE-1:0][CNT_W-1:0] counts;

    dg_resource_check #(
        .UOP_W (UOP_W),
        .DST_W (DST_W),
        .BUF_W (BUF_W),
        .FREE_W(FREE_W)
    ) u_check (
        .need_uops  (in_uops),
        .need_dsts  (in_dsts),
        .need_bufs  (in_bufs),
        .rob_free   (rob_free),
        .preg_free  (preg_free),
        .sbuf_free  (sbuf_free),
        .width_block(width_block),
        .verdict    (verdict)
    );

    assign in_ready  = verdict.ok;
    assign accept    = in_valid && verdict.ok;
    assign stall_evt = in_valid && !verdict.ok;

    dg_slots #(
        .DISP_W(DISP_W),
        .UOP_W (UOP_W),
        .SLOT_W(SLOT_W)
    ) u_slots (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .new_uops   (in_uops),
        .carry_q    (carry_q),
        .width_block(width_block),
        .disp_uops  (disp_uops),
        .done_carry (done_carry),
        .done_new   (done_new)
    );

    assign alloc        = accept;
    assign rob_alloc_n  = accept ? in_uops : '0;
    assign preg_alloc_n = accept ? in_dsts : '0;
    assign sbuf_alloc_n = accept ? in_bufs : '0;

    dg_stall_bank #(
        .NCAUSE(DG_NCAUSE),
        .CNT_W (CNT_W)
    ) u_stalls (
        .clk      (clk),
        .rst      (rst),
        .stall_evt(stall_evt),
        .cause    (verdict.cause),
        .counts   (counts)
    );

    assign stall_rob   = counts[0];
    assign stall_preg  = counts[1];
    assign stall_sbuf  = counts[2];
    assign stall_width = counts[3];

endmodule

// File: rtl/dg_sva.sv
module dg_sva #(
    parameter int unsigned DISP_W = 4,
    parameter int unsigned UOP_W  = 4,
    parameter int unsigned DST_W  = 3,
    parameter int unsigned BUF_W  = 3,
    parameter int unsigned FREE_W = 7,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned SLOT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [UOP_W-1:0]  in_uops,
    input logic [DST_W-1:0]  in_dsts,
    input logic [BUF_W-1:0]  in_bufs,
    input logic [FREE_W-1:0] rob_free,
    input logic [FREE_W-1:0] preg_free,
    input logic [FREE_W-1:0] sbuf_free,
    input logic              alloc,
    input logic [UOP_W-1:0]  rob_alloc_n,
    input logic [DST_W-1:0]  preg_alloc_n,
    input logic [BUF_W-1:0]  sbuf_alloc_n,
    input logic [SLOT_W-1:0] disp_uops,
    input logic              done_carry,
    input logic              done_new,
    input logic [CNT_W-1:0]  stall_rob,
    input logic [CNT_W-1:0]  stall_preg,
    input logic [CNT_W-1:0]  stall_sbuf,
    input logic [CNT_W-1:0]  stall_width,
    input logic [UOP_W-1:0]  carry_q
);

    p_rob_gate_r1: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (32'(in_uops) <= 32'(rob_free)));

    p_preg_gate_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (32'(in_dsts) <= 32'(preg_free)));

    p_sbuf_gate_r3: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (32'(in_bufs) <= 32'(sbuf_free)));

    p_width_cap_r4: assert property (@(posedge clk) disable iff (rst)
        32'(disp_uops) <= DISP_W);

    p_carry_block_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(carry_q) >= DISP_W) |-> !in_ready);

    p_carry_drain_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(carry_q) > DISP_W) |=> (32'(carry_q) == 32'($past(carry_q)) - DISP_W));

    p_alloc_valid_r7: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (in_valid && rob_alloc_n == in_uops && preg_alloc_n == in_dsts
                   && sbuf_alloc_n == in_bufs));

    p_alloc_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !alloc |-> (rob_alloc_n == '0 && preg_alloc_n == '0 && sbuf_alloc_n == '0));

    p_stall_mono_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stall_rob >= $past(stall_rob) && stall_preg >= $past(stall_preg)
                  && stall_sbuf >= $past(stall_sbuf) && stall_width >= $past(stall_width)));

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (stall_rob == '1) |=> (stall_rob == '1));

    p_done_new_r10: assert property (@(posedge clk) disable iff (rst)
        done_new |-> alloc);

    p_done_carry_r10: assert property (@(posedge clk) disable iff (rst)
        done_carry |-> (carry_q != '0 && 32'(carry_q) <= DISP_W));

endmodule

bind dispatch_gate dg_sva #(
    .DISP_W(DISP_W),
    .UOP_W (UOP_W),
    .DST_W (DST_W),
    .BUF_W (BUF_W),
    .FREE_W(FREE_W),
    .CNT_W (CNT_W),
    .SLOT_W(SLOT_W)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_uops     (in_uops),
    .in_dsts     (in_dsts),
    .in_bufs     (in_bufs),
    .rob_free    (rob_free),
    .preg_free   (preg_free),
    .sbuf_free   (sbuf_free),
    .alloc       (alloc),
    .rob_alloc_n (rob_alloc_n),
    .preg_alloc_n(preg_alloc_n),
    .sbuf_alloc_n(sbuf_alloc_n),
    .disp_uops   (disp_uops),
    .done_carry  (done_carry),
    .done_new    (done_new),
    .stall_rob   (stall_rob),
    .stall_preg  (stall_preg),
    .stall_sbuf  (stall_sbuf),
    .stall_width (stall_width),
    .carry_q     (carry_q)
);

// File: tb/test_dispatch_gate.sv
`timescale 1ns/1ps
module test_dispatch_gate;

    localparam int W      = 4;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_uops = '0;
    logic [2:0] in_dsts = '0;
    logic [2:0] in_bufs = '0;
    logic [6:0] rob_free = '0;
    logic [6:0] preg_free = '0;
    logic [6:0] sbuf_free = '0;
    logic       in_ready;
    logic       alloc;
    logic [3:0] rob_alloc_n;
    logic [2:0] preg_alloc_n;
    logic [2:0] sbuf_alloc_n;
    logic [2:0] disp_uops;
    logic       done_carry;
    logic       done_new;
    logic [CNT_W-1:0] stall_rob, stall_preg, stall_sbuf, stall_width;

    int checks = 0;
    int errors = 0;
    int m_carry = 0;
    int m_cnt [4] = '{0, 0, 0, 0};
    bit finished = 0;

    always #4 clk = ~clk;

    dispatch_gate #(.DISP_W(W), .CNT_W(CNT_W)) i_dispatch_gate (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
        .in_dsts(in_dsts), .in_bufs(in_bufs), .in_ready(in_ready),
        .rob_free(rob_free), .preg_free(preg_free), .sbuf_free(sbuf_free),
        .alloc(alloc), .rob_alloc_n(rob_alloc_n), .preg_alloc_n(preg_alloc_n),
        .sbuf_alloc_n(sbuf_alloc_n), .disp_uops(disp_uops),
        .done_carry(done_carry), .done_new(done_new),
        .stall_rob(stall_rob), .stall_preg(stall_preg),
        .stall_sbuf(stall_sbuf), .stall_width(stall_width)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check_counters();
        chk((m_cnt[0] == CMAX) ? "R9" : "R8", "stall_rob",   int'(stall_rob),   m_cnt[0]);
        chk((m_cnt[1] == CMAX) ? "R9" : "R8", "stall_preg",  int'(stall_preg),  m_cnt[1]);
        chk((m_cnt[2] == CMAX) ? "R9" : "R8", "stall_sbuf",  int'(stall_sbuf),  m_cnt[2]);
        chk((m_cnt[3] == CMAX) ? "R9" : "R8", "stall_width", int'(stall_width), m_cnt[3]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_carry = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        #1;
        // R11: carry-over and counters cleared; an idle cycle dispatches nothing.
        chk("R11", "disp_uops after reset", int'(disp_uops), 0);
        chk("R11", "done_carry after reset", int'(done_carry), 0);
        chk("R11", "stall_rob after reset", int'(stall_rob), 0);
        chk("R11", "stall_width after reset", int'(stall_width), 0);
    endtask

    task automatic step(input bit v, input int u, input int d, input int b,
                        input int rf, input int pf, input int sf);
        int served, rest, avail, new_now;
        bit rs, ps, ss, wb, ok, acc;
        string rq;
        @(negedge clk);
        in_valid = v;
        in_uops = 4'(u);  in_dsts = 3'(d);  in_bufs = 3'(b);
        rob_free = 7'(rf); preg_free = 7'(pf); sbuf_free = 7'(sf);
        #1;
        served  = imin(m_carry, W);
        rest    = m_carry - served;
        avail   = W - served;
        wb      = (avail == 0);
        rs      = u > rf;
        ps      = d > pf;
        ss      = b > sf;
        ok      = !(rs || ps || ss || wb);
        acc     = v && ok;
        new_now = acc ? imin(u, avail) : 0;
        rq = rs ? "R1" : ps ? "R2" : ss ? "R3" : wb ? "R5" : "R6";
        chk(rq, "in_ready", int'(in_ready), int'(ok));
        chk("R7", "alloc", int'(alloc), int'(acc));
        chk("R7", "rob_alloc_n", int'(rob_alloc_n), acc ? u : 0);
        chk("R7", "preg_alloc_n", int'(preg_alloc_n), acc ? d : 0);
        chk("R7", "sbuf_alloc_n", int'(sbuf_alloc_n), acc ? b : 0);
        chk("R4", "disp_uops", int'(disp_uops), served + new_now);
        chk("R10", "done_carry", int'(done_carry), int'(m_carry != 0 && rest == 0));
        chk("R10", "done_new", int'(done_new), int'(acc && u <= avail));
        check_counters();
        @(posedge clk);
        m_carry = rest + (acc ? (u - new_now) : 0);
        if (v && !ok) begin
            int c;
            c = rs ? 0 : ps ? 1 : ss ? 2 : 3;
            if (m_cnt[c] < CMAX) m_cnt[c]++;
        end
    endtask

    initial begin
        do_reset();
        // R6: small instruction, plenty of room
        step(1, 3, 1, 1, 50, 50, 50);
        // R5: oversized instruction, then width stall, then leftover slots used (R6)
        step(1, 11, 2, 2, 50, 50, 50);
        step(1, 2, 1, 1, 50, 50, 50);
        step(1, 2, 1, 1, 50, 50, 50);
        step(1, 3, 1, 1, 50, 50, 50);
        // R5: exactly DISP_W carried blocks the next instruction
        step(1, 8, 0, 0, 50, 50, 50);
        step(1, 1, 0, 0, 50, 50, 50);
        step(0, 0, 0, 0, 50, 50, 50);
        // R1/R2/R3: each resource short alone, exact fit passes
        step(1, 3, 1, 1, 2, 50, 50);
        step(1, 3, 1, 1, 3, 50, 50);
        step(1, 2, 4, 1, 50, 3, 50);
        step(1, 2, 4, 1, 50, 4, 50);
        step(1, 2, 1, 5, 50, 50, 4);
        step(1, 2, 1, 5, 50, 50, 5);
        // R8: priority when several are short at once
        step(1, 4, 4, 4, 0, 0, 0);
        step(1, 4, 4, 4, 9, 0, 0);
        step(1, 4, 4, 4, 9, 9, 0);
        step(1, 15, 0, 0, 50, 50, 50);
        step(1, 4, 0, 0, 0, 50, 50);
        step(1, 4, 0, 0, 50, 50, 50);
        step(1, 0, 0, 0, 50, 50, 50);
        // R10: zero micro-op instruction completes at once
        step(1, 0, 0, 0, 0, 0, 0);
        // R7: idle cycle with valid low
        step(0, 5, 3, 3, 50, 50, 50);
        // R9: saturate the reorder-buffer stall counter
        for (int i = 0; i < 20; i++) step(1, 6, 0, 0, 1, 50, 50);
        // R11: reset in the middle of a carry-over
        step(1, 13, 1, 1, 50, 50, 50);
        do_reset();
        step(1, 2, 1, 1, 50, 50, 50);
        // mixed patterns
        for (int i = 0; i < 600; i++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 7),
                 $urandom_range(0, 7), $urandom_range(0, 18), $urandom_range(0, 9),
                 $urandom_range(0, 9));
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule